// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block runs on the master side of a two-wire serial bus and brings a memory slave back to a known idle state when the master has lost its place in a transfer. The usual trigger is a master that was reset, for example during a supply dip, while the slave kept pulling the data line low to send a zero bit or an acknowledge. On request, the block drives a fixed recovery pattern on the open-drain clock and data pins. First comes a start condition. Then come nine clock pulses with data released, which let the slave finish whatever bit it was holding. Next comes a second start, placed directly after the ninth pulse. A stop ends the pattern.

The second start sits between the dummy clocks and the stop. This keeps the slave from reading the stop as the end of a write. The clock never pulses again between the ninth dummy clock and that start. Every phase of the pattern lasts a programmable number of system clocks. While the block releases the clock line, it waits for the line to read high, so a slave that holds the clock low stretches the phase. An optional launch after reset runs the pattern once before the block signals that other bus traffic may begin. At the end, a status bit reports whether the data line reads high, so a slave that is still stuck can be detected.

Top module: `busrec_top`

## Requirements
- R1: While no sequence runs, including during reset, `scl_oe` and `sda_oe` are both 0 (both lines released) and `busy` is 0.
- R2: A sequence starts with a start condition: the first change on the pin drives is `sda_oe` going to 1 while `scl_oe` stays 0.
- R3: After the first start, exactly nine clock pulses follow (`scl_oe` 0 to 1 to 0), and `sda_oe` is 0 for their whole span. The ordered list of drive states, written {scl_oe,sda_oe}, is 01, 11, 10, then nine times 00, 10.
- R4: After the ninth pulse's low phase, the clock is released once (00) and the second start follows at once (01). No further clock pulse occurs.
- R5: The sequence ends with a stop: `sda_oe` returns to 0 while `scl_oe` stays 0, and the block then goes idle.
- R6: `scl_oe` and `sda_oe` never change in the same system clock cycle.
- R7: Every phase lasts max(`div_i`, SYNC_STAGES)+1 system clocks, with `div_i` latched at launch. A dummy-clock low phase therefore drives `scl_oe` high for exactly that many cycles, and the first low stretch (start hold plus data release) lasts twice that.
- R8: `busy` stays high from launch to the end of the stop phase. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: With `done`, `sda_ok` takes the synchronized level of `sda_in` at the end of the stop phase: 1 for a released line, 0 for a line still held low.
- R10: A `req` pulse while `busy` is high is ignored: no second sequence, no extra pin change, no extra `done`.
- R11: In a phase where the clock is released, the block does not move to the next phase while the synchronized `scl_in` reads low. The drives stay unchanged for that time.
- R12: If `auto_mode` is 1 when reset is released, one sequence starts without `req`, and `bus_ready` stays 0 until it ends. If `auto_mode` is 0, `bus_ready` goes to 1 right after reset. Once `bus_ready` is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | Run one sequence right after reset release |
| req | input | 1 | Start a sequence (single-cycle pulse, ignored while busy) |
| div_i | input | DIV_W | Phase length in system clocks, minus one |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| sda_ok | output | 1 | Data line read high at the end of the last sequence |
| bus_ready | output | 1 | Other bus traffic allowed |

## Verification
The bench builds the block with DIV_W=6 and SYNC_STAGES=2. This makes the largest divider value, 63, cheap enough to run a full sequence at it. The bench also runs divider values below the synchronizer floor (0), in the middle (3, 4, 5) and at the top (63), so both the clamp and the unclamped paths are measured. A held clock line, a data line stuck low, a repeated request and both reset launch modes are applied against a queue of expected drive states and low-phase lengths.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef int unsigned uint_t;

  // Drive state of the two open-drain pins: 1 means pull low.
  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } pin_drive_t;

  // Phases: pre-idle, start, clock low, data release, 2*n dummy phases,
  // clock rise, second start, stop.
  function automatic uint_t step_total(uint_t n_dummy);
    return 2 * n_dummy + 7;
  endfunction

  function automatic logic is_dummy(uint_t idx, uint_t n_dummy);
    return (idx >= 4) && (idx < 4 + 2 * n_dummy);
  endfunction

  function automatic pin_drive_t step_drive(uint_t idx, uint_t n_dummy);
    pin_drive_t d;
    d.scl_low = 1'b0;
    d.sda_low = 1'b0;
    if (idx == 1) begin
      d.sda_low = 1'b1;
    end else if (idx == 2) begin
      d.scl_low = 1'b1;
      d.sda_low = 1'b1;
    end else if (idx == 3) begin
      d.scl_low = 1'b1;
    end else if (is_dummy(idx, n_dummy)) begin
      d.scl_low = ((idx - 4) % 2) == 1;
    end else if (idx == 4 + 2 * n_dummy + 1) begin
      d.sda_low = 1'b1;
    end
    return d;
  endfunction

  // Effective phase limit: never shorter than the input synchronizer depth,
  // so a released line is seen with its true level before a phase may end.
  function automatic uint_t eff_div(uint_t div, uint_t floor_v);
    return (div < floor_v) ? floor_v : div;
  endfunction

  function automatic uint_t phase_cycles(uint_t div, uint_t floor_v);
    return eff_div(div, floor_v) + 1;
  endfunction

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[0] <= '1;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[k] <= '1;
          else        st[k] <= st[k-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/busrec_timer.sv
module busrec_timer
  import busrec_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run,
  input  logic             may_end,
  output logic             step_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             at_lim;

  assign at_lim   = (cnt == lim);
  assign step_end = run && at_lim && may_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else if (load) begin
      cnt <= '0;
      lim <= DIV_W'(eff_div(uint_t'(div_i), SYNC_STAGES));
    end else if (run) begin
      if (step_end)     cnt <= '0;
      else if (!at_lim) cnt <= cnt + 1'b1;
    end
  end

  // R7: the phase counter never runs past the latched limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int unsigned DUMMY_CLOCKS = 9,
  parameter int unsigned IDX_W        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic auto_mode,
  input  logic step_end,
  input  logic scl_hi,
  input  logic sda_hi,
  output logic launch,
  output logic may_end,
  output logic busy,
  output logic done,
  output logic sda_ok,
  output logic bus_ready,
  output logic scl_low,
  output logic sda_low
);
  localparam uint_t LAST = step_total(DUMMY_CLOCKS) - 1;

  logic [IDX_W-1:0] idx;
  logic             auto_pend;
  logic             seq_end;
  logic             in_dummy;
  pin_drive_t       drive;

  assign drive    = step_drive(uint_t'(idx), DUMMY_CLOCKS);
  assign in_dummy = is_dummy(uint_t'(idx), DUMMY_CLOCKS);
  assign launch   = !busy && (auto_pend ? auto_mode : req);
  assign seq_end  = busy && step_end && (idx == IDX_W'(LAST));
  assign may_end  = drive.scl_low || scl_hi;
  assign scl_low  = busy && drive.scl_low;
  assign sda_low  = busy && drive.sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      done      <= 1'b0;
      sda_ok    <= 1'b0;
      auto_pend <= 1'b1;
      bus_ready <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && auto_pend) begin
        auto_pend <= 1'b0;
        if (!auto_mode) bus_ready <= 1'b1;
      end
      if (launch) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (seq_end) begin
        busy      <= 1'b0;
        idx       <= '0;
        done      <= 1'b1;
        sda_ok    <= sda_hi;
        bus_ready <= 1'b1;
      end else if (busy && step_end) begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R3: data stays released through every dummy clock phase
  a_r3_sda_free_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_dummy) |-> !sda_low);
  // R10: once running, only the final phase end may drop busy
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_end) |=> busy);
  // R11: a released clock sensed low freezes the phase
  a_r11_stretch_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drive.scl_low && !scl_hi) |=> $stable(idx));
  // R12: traffic permission is never withdrawn
  a_r12_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> bus_ready);
endmodule

// File: rtl/busrec_top.sv
module busrec_top
  import busrec_pkg::*;
#(
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned DUMMY_CLOCKS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic             req,
  input  logic [DIV_W-1:0] div_i,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             sda_ok,
  output logic             bus_ready
);
  localparam int unsigned IDX_W = $clog2(step_total(DUMMY_CLOCKS));

  logic [1:0] sensed;
  logic       launch_w;
  logic       may_end_w;
  logic       step_end_w;

  busrec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (sensed)
  );

  busrec_timer #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch_w),
    .div_i    (div_i),
    .run      (busy),
    .may_end  (may_end_w),
    .step_end (step_end_w)
  );

  busrec_seq #(.DUMMY_CLOCKS(DUMMY_CLOCKS), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .auto_mode (auto_mode),
    .step_end  (step_end_w),
    .scl_hi    (sensed[1]),
    .sda_hi    (sensed[0]),
    .launch    (launch_w),
    .may_end   (may_end_w),
    .busy      (busy),
    .done      (done),
    .sda_ok    (sda_ok),
    .bus_ready (bus_ready),
    .scl_low   (scl_oe),
    .sda_low   (sda_oe)
  );

  // R6: the two pin drives never move together
  a_r6_one_pin_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));
  // R1: idle bus is fully released
  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: done marks the first idle cycle after a run
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/busrec_top_tb_top.sv
module busrec_top_tb_top;
  localparam int unsigned DIV_W = 6;
  localparam int unsigned SYNC  = 2;
  localparam int unsigned NDUM  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode = 1'b0;
  logic req = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic hold_scl = 1'b0;
  logic stuck_sda = 1'b0;
  logic scl_oe, sda_oe, busy, done, sda_ok, bus_ready;
  logic scl_in, sda_in;

  assign scl_in = !scl_oe && !hold_scl;
  assign sda_in = !sda_oe && !stuck_sda;

  always #5 clk = ~clk;

  busrec_top #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC), .DUMMY_CLOCKS(NDUM)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .req(req), .div_i(div_i),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .sda_ok(sda_ok), .bus_ready(bus_ready)
  );

  int checks = 0;
  int failures = 0;
  int done_seen = 0;
  bit finished = 0;
  logic [1:0] pin_q [$];
  int span_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_len(int d);
    return ((d < int'(SYNC)) ? int'(SYNC) : d) + 1;
  endfunction

  // Driver side: expected drive states {scl_oe,sda_oe} and low-phase lengths
  task automatic expect_run(input int d);
    pin_q.push_back(2'b01);
    pin_q.push_back(2'b11);
    pin_q.push_back(2'b10);
    span_q.push_back(2 * low_len(d));
    for (int k = 0; k < int'(NDUM); k++) begin
      pin_q.push_back(2'b00);
      pin_q.push_back(2'b10);
      span_q.push_back(low_len(d));
    end
    pin_q.push_back(2'b00);
    pin_q.push_back(2'b01);
    pin_q.push_back(2'b00);
  endtask

  // Monitor side
  logic [1:0] prev_pins = 2'b00;
  logic prev_done = 1'b0;
  int low_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] cur;
      cur = {scl_oe, sda_oe};
      if (cur != prev_pins) begin
        chk(!(cur[1] != prev_pins[1] && cur[0] != prev_pins[0]), "R6 both pins changed",
            int'(cur), int'(prev_pins));
        if (pin_q.size() == 0) begin
          chk(1'b0, "R10 unexpected pin change", int'(cur), -1);
        end else begin
          logic [1:0] e;
          e = pin_q.pop_front();
          chk(cur == e, "R2 R3 R4 R5 drive order", int'(cur), int'(e));
        end
      end
      if (cur[1]) low_cnt++;
      else if (prev_pins[1]) begin
        if (span_q.size() == 0) chk(1'b0, "R7 unexpected low phase", low_cnt, -1);
        else begin
          int es;
          es = span_q.pop_front();
          chk(low_cnt == es, "R7 clock low length", low_cnt, es);
        end
        low_cnt = 0;
      end
      if (done) begin
        done_seen++;
        chk(!busy, "R8 done while busy", int'(busy), 0);
        chk(!prev_done, "R8 done longer than one cycle", 2, 1);
      end
      prev_pins = cur;
      prev_done = done;
    end else begin
      prev_pins = 2'b00;
      prev_done = 1'b0;
      low_cnt = 0;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic after_run(input bit exp_ok, input string tag);
    chk(sda_ok == exp_ok, tag, int'(sda_ok), int'(exp_ok));
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1 idle after run", int'({busy, scl_oe, sda_oe}), 0);
    chk(pin_q.size() == 0, "R5 sequence incomplete", pin_q.size(), 0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    int d0;
    // Reset state, auto launch armed
    auto_mode = 1'b1;
    div_i = 6'd3;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !bus_ready, "R1 reset state",
        int'({scl_oe, sda_oe, busy, done, bus_ready}), 0);
    expect_run(3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy, "R12 auto launch without req", int'(busy), 1);
    chk(!bus_ready, "R12 traffic held during auto run", int'(bus_ready), 0);
    wait_done();
    chk(bus_ready, "R12 traffic allowed after auto run", int'(bus_ready), 1);
    after_run(1'b1, "R9 released line reads high");
    repeat (20) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R1 stays idle", int'({busy, scl_oe, sda_oe}), 0);

    // Divider below the floor, plus a request while busy
    div_i = 6'd0;
    d0 = done_seen;
    expect_run(0);
    pulse_req();
    div_i = 6'd40;
    repeat (20) @(negedge clk);
    pulse_req();
    wait_done();
    after_run(1'b1, "R9 normal end");
    repeat (100) @(negedge clk);
    chk(done_seen == d0 + 1, "R10 request while busy ignored", done_seen, d0 + 1);
    chk(!busy, "R10 no second run", int'(busy), 0);

    // Largest divider value
    div_i = 6'd63;
    expect_run(63);
    pulse_req();
    wait_done();
    after_run(1'b1, "R9 end at max divider");

    // Stuck data line
    div_i = 6'd5;
    stuck_sda = 1'b1;
    expect_run(5);
    pulse_req();
    wait_done();
    after_run(1'b0, "R9 stuck line flagged");
    stuck_sda = 1'b0;

    // Clock held low by the slave during the first dummy high phase
    div_i = 6'd4;
    expect_run(4);
    pulse_req();
    while (!scl_oe) @(negedge clk);
    hold_scl = 1'b1;
    while (scl_oe) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (scl_oe || sda_oe)
        chk(1'b0, "R11 phase advanced while clock held", int'({scl_oe, sda_oe}), 0);
    end
    chk(busy && !scl_oe && !sda_oe, "R11 held in released phase",
        int'({busy, scl_oe, sda_oe}), 4);
    hold_scl = 1'b0;
    wait_done();
    after_run(1'b1, "R9 end after stretch");

    // Reset without auto launch
    @(negedge clk) rst_n = 1'b0;
    auto_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_ready && !busy, "R1 reset clears state", int'({bus_ready, busy}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_ready, "R12 traffic allowed at once", int'(bus_ready), 1);
    repeat (30) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R12 no launch without auto mode",
        int'({busy, scl_oe, sda_oe}), 0);
    chk(pin_q.size() == 0 && span_q.size() == 0, "R3 all items consumed",
        pin_q.size() + span_q.size(), 0);

    finished = 1;
    report();
  end
endmodule